// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog for a processor subsystem. A slow-clock enable pulse steps a prescaler that divides by a parameter (128 by default). Each prescaler wrap steps a down counter that is 12 bits wide by default. Software must restart the counter before it runs past zero. If it does not, the block raises a fault toward the reset controller and, if enabled, an interrupt.

A restart may also come too early. When the window is active, a restart issued while the counter is still above the delta value is treated as a runaway-software symptom and flagged as an error. The restart is then not performed. This check runs even while counting is switched off. The configuration word can be written once per reset. A short lockout after each restart protects it from a write that comes too soon. Reading the status word clears the flags, the fault and the interrupt.

The register port has three word addresses: 0 is the control word, 1 is the configuration word and 2 is the status word. Reads return data combinationally in the same cycle as the read strobe.

Top module: `win_watchdog`

## Requirements
- R1: Counting is gated by `slow_tick` pulses that are not suppressed. The counter drops by one on every PRESC_DIV-th counting pulse. After a reload to value V with the prescaler cleared, the underflow is registered on counting pulse number (V+1)*PRESC_DIV, and the counter reloads from the configured reload value.
- R2: An underflow sets the underflow flag, which is status bit 0. `fault_o` rises with it only when the reset-enable bit (configuration bit 12) is 1.
- R3: A control write acts only when bits [31:24] equal 0xA5. A restart is requested by bit 0. A control write with any other key leaves the counter, the prescaler and the flags unchanged.
- R4: An accepted restart reloads the counter from the reload value and clears the prescaler in the same clock edge.
- R5: Suppose the delta value (configuration bits [27:16]) is below the reload value (bits [11:0]). A restart requested while the counter is greater than the delta sets the error flag (status bit 1) and asserts `fault_o`. Such a restart does not reload, and the check applies even while counting is disabled.
- R6: When the delta is greater than or equal to the reload value, a restart is accepted at every counter value without an error.
- R7: Only the first accepted configuration write after reset takes effect. It also acts as a restart with the new reload value. Later writes leave the configuration unchanged.
- R8: A configuration write is ignored while fewer than 3 `slow_tick` pulses have passed since an accepted restart. An ignored write does not use up the single allowed write.
- R9: After reset, the reload and delta fields read as all ones of the counter width, reset-enable reads 1, every other configuration bit reads 0, and both flags, `fault_o` and `irq_o` are 0.
- R10: `irq_o` is high while either flag is set and the interrupt-enable bit (configuration bit 13) is 1.
- R11: Reading the status word returns the flags and clears both of them. In the following cycle `fault_o` and `irq_o` drop, unless a new event arrives in the same cycle.
- R12: Counting and the prescaler freeze while `idle_i` is high with configuration bit 28 set, and while `dbg_i` is high with configuration bit 29 set.
- R13: While the disable bit (configuration bit 14) is 1, the counter never advances and no underflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle pulse per slow-clock period |
| idle_i | input | 1 | Processor idle indication |
| dbg_i | input | 1 | Processor debug indication |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Word address: 0 control, 1 configuration, 2 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the strobe cycle |
| fault_o | output | 1 | Fault request to the reset controller |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench runs a small configuration: a 6-bit counter and a divide-by-4 prescaler. It sweeps the restart point across every counter value for a window that is on and for one that is off. The first sweep separates early restarts, which must set the error flag and leave the counter untouched, from late ones, which must reload it. The second sweep shows that an open window never reports an error. Underflow timing is probed one pulse before and exactly at the computed pulse count, from reset, after a bad-key write and after a good restart, which tells a real reload apart from a write that was ignored. Idle and debug freezes, the disable bit, the write lockout and the single configuration write are each exercised on their own.

// File: rtl/wd_pkg.sv
package wd_pkg;

    localparam logic [7:0] CTRL_KEY = 8'hA5;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_CFG    = 2'd1;
    localparam logic [1:0] ADDR_STATUS = 2'd2;

    localparam int CFG_WDD_LSB   = 16;
    localparam int CFG_RSTEN_BIT = 12;
    localparam int CFG_IRQEN_BIT = 13;
    localparam int CFG_DIS_BIT   = 14;
    localparam int CFG_IDLE_BIT  = 28;
    localparam int CFG_DBG_BIT   = 29;

    localparam int LOCK_TICKS = 3;

    typedef struct packed {
        logic dbg_halt;
        logic idle_halt;
        logic dis;
        logic irq_en;
        logic rst_en;
    } wd_ctl_t;

    localparam wd_ctl_t CTL_RESET = '{dbg_halt: 1'b0, idle_halt: 1'b0,
                                      dis: 1'b0, irq_en: 1'b0, rst_en: 1'b1};

    function automatic wd_ctl_t ctl_from_word(input logic [31:0] w);
        wd_ctl_t c;
        c.dbg_halt  = w[CFG_DBG_BIT];
        c.idle_halt = w[CFG_IDLE_BIT];
        c.dis       = w[CFG_DIS_BIT];
        c.irq_en    = w[CFG_IRQEN_BIT];
        c.rst_en    = w[CFG_RSTEN_BIT];
        return c;
    endfunction

    function automatic logic [31:0] ctl_to_word(input wd_ctl_t c);
        logic [31:0] w;
        w = '0;
        w[CFG_DBG_BIT]   = c.dbg_halt;
        w[CFG_IDLE_BIT]  = c.idle_halt;
        w[CFG_DIS_BIT]   = c.dis;
        w[CFG_IRQEN_BIT] = c.irq_en;
        w[CFG_RSTEN_BIT] = c.rst_en;
        return w;
    endfunction

endpackage

// File: rtl/wd_prescaler.sv
module wd_prescaler #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step_en,
    output logic wrap
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            phase_q <= '0;
        end else if (step_en) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
    end

    assign wrap = step_en && !clear && (phase_q == LAST);

endmodule

// File: rtl/wd_counter.sv
module wd_counter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         uflow
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '1;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec) begin
            cnt_q <= (cnt_q == '0) ? load_val : cnt_q - 1'b1;
        end
    end

    assign cnt   = cnt_q;
    assign uflow = dec && !load && (cnt_q == '0);

endmodule

// File: rtl/wd_regfile.sv
module wd_regfile
    import wd_pkg::*;
#(
    parameter int W = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          slow_tick,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic [W-1:0]  cnt,
    input  logic          uflow,
    output wd_ctl_t       ctl,
    output logic          reload,
    output logic [W-1:0]  reload_val,
    output logic          unf_flag,
    output logic          fault_o,
    output logic          irq_o
);
    logic [W-1:0] wdv_q, wdd_q;
    wd_ctl_t      ctl_q;
    logic         cfg_done_q;
    logic [1:0]   lock_q;
    logic         unf_q, err_q;

    logic ctrl_wr, key_ok, restart_req, window_on, early, good_restart;
    logic cfg_wr_ok, status_rd;

    assign ctrl_wr      = reg_wr && (reg_addr == ADDR_CTRL);
    assign key_ok       = (reg_wdata[31:24] == CTRL_KEY);
    assign restart_req  = ctrl_wr && key_ok && reg_wdata[0];
    assign window_on    = (wdd_q < wdv_q);
    assign early        = restart_req && window_on && (cnt > wdd_q);
    assign good_restart = restart_req && !early;
    assign cfg_wr_ok    = reg_wr && (reg_addr == ADDR_CFG) && !cfg_done_q && (lock_q == 2'd0);
    assign status_rd    = reg_rd && (reg_addr == ADDR_STATUS);

    assign reload     = good_restart || cfg_wr_ok;
    assign reload_val = cfg_wr_ok ? reg_wdata[W-1:0] : wdv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wdv_q      <= '1;
            wdd_q      <= '1;
            ctl_q      <= CTL_RESET;
            cfg_done_q <= 1'b0;
        end else if (cfg_wr_ok) begin
            wdv_q      <= reg_wdata[W-1:0];
            wdd_q      <= reg_wdata[CFG_WDD_LSB +: W];
            ctl_q      <= ctl_from_word(reg_wdata);
            cfg_done_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= '0;
        end else if (good_restart) begin
            lock_q <= 2'(LOCK_TICKS);
        end else if (slow_tick && lock_q != 2'd0) begin
            lock_q <= lock_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            unf_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            unf_q <= uflow || (unf_q && !status_rd);
            err_q <= early || (err_q && !status_rd);
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                ADDR_CFG: begin
                    reg_rdata = ctl_to_word(ctl_q);
                    reg_rdata[W-1:0] = wdv_q;
                    reg_rdata[CFG_WDD_LSB +: W] = wdd_q;
                end
                ADDR_STATUS: reg_rdata[1:0] = {err_q, unf_q};
                default: reg_rdata = '0;
            endcase
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^reg_wdata;

    assign ctl      = ctl_q;
    assign unf_flag = unf_q;
    assign fault_o  = (unf_q && ctl_q.rst_en) || err_q;
    assign irq_o    = ctl_q.irq_en && (unf_q || err_q);

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        cfg_done_q |=> $stable({wdv_q, wdd_q, ctl_q})) else $error("cfg changed"); // R7
    AST_BADKEY_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !key_ok && !err_q) |=> !err_q) else $error("bad key set err"); // R3
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (status_rd && !uflow && !early) |=> (!fault_o && !irq_o)) else $error("no clear"); // R11
    AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_CFG && lock_q != 2'd0) |=> $stable(cfg_done_q)) else $error("lock"); // R8

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
    import wd_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int PRESC_DIV = 128
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        slow_tick,
    input  logic        idle_i,
    input  logic        dbg_i,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        fault_o,
    output logic        irq_o
);
    wd_ctl_t          ctl;
    logic             reload, step_en, dec, uflow, unf_flag;
    logic [CNT_W-1:0] reload_val, cnt;

    assign step_en = slow_tick && !ctl.dis
                     && !(idle_i && ctl.idle_halt)
                     && !(dbg_i && ctl.dbg_halt);

    wd_prescaler #(.DIV(PRESC_DIV)) u_presc (
        .clk(clk), .rst(rst), .clear(reload), .step_en(step_en), .wrap(dec)
    );

    wd_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .load(reload), .load_val(reload_val),
        .dec(dec), .cnt(cnt), .uflow(uflow)
    );

    wd_regfile #(.W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .slow_tick(slow_tick),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cnt(cnt), .uflow(uflow), .ctl(ctl),
        .reload(reload), .reload_val(reload_val),
        .unf_flag(unf_flag), .fault_o(fault_o), .irq_o(irq_o)
    );

    AST_HOLD_WHEN_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!step_en && !reload) |=> $stable(cnt)) else $error("counter moved"); // R12
    AST_UNF_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(unf_flag) |-> ($past(cnt) == '0)) else $error("unf not at zero"); // R1
    AST_DISABLED_NO_UNF: assert property (@(posedge clk) disable iff (rst)
        (ctl.dis && !unf_flag) |=> !unf_flag) else $error("unf while off"); // R13

endmodule

// File: tb/test_win_watchdog.sv
`timescale 1ns/1ps
module test_win_watchdog;
    localparam int W = 6;
    localparam int D = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic slow_tick = 1'b0, idle_i = 1'b0, dbg_i = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic fault_o, irq_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    win_watchdog #(.CNT_W(W), .PRESC_DIV(D)) i_win_watchdog (
        .clk(clk), .rst(rst), .slow_tick(slow_tick), .idle_i(idle_i), .dbg_i(dbg_i),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fault_o(fault_o), .irq_o(irq_o)
    );

    localparam logic [31:0] RESTART = 32'hA500_0001;

    function automatic logic [31:0] cfg(input int wdv, input int wdd, input bit rsten,
                                        input bit irqen, input bit dis, input bit ih, input bit dh);
        logic [31:0] w;
        w = 32'(wdv) | (32'(wdd) << 16);
        w[12] = rsten; w[13] = irqen; w[14] = dis; w[28] = ih; w[29] = dh;
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            slow_tick = 1'b1; @(negedge clk);
            slow_tick = 1'b0; @(negedge clk);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        logic [31:0] d;
        int cur;
        @(negedge clk);
        do_reset();

        // R9 reset state
        check("R9 fault", 32'(fault_o), 0);
        check("R9 irq", 32'(irq_o), 0);
        rd(2'd1, d); check("R9 cfg default", d, 32'h003F_103F);
        rd(2'd2, d); check("R9 status", d, 0);

        // R1/R2 underflow from reset value 63
        ticks(64 * D - 1); check("R1 no early unf", 32'(fault_o), 0);
        ticks(1);          check("R2 fault on unf", 32'(fault_o), 1);
        check("R10 irq off when disabled", 32'(irq_o), 0);
        rd(2'd2, d); check("R11 status unf", d, 1);
        check("R11 fault cleared", 32'(fault_o), 0);

        // R3 bad key ignored
        ticks(100);
        wr(2'd0, 32'h5A00_0001);
        ticks(64 * D - 101); check("R3 bad key no reload", 32'(fault_o), 0);
        ticks(1);            check("R3 schedule kept", 32'(fault_o), 1);
        rd(2'd2, d); check("R3 no err", d, 1);

        // R4 good restart reloads
        ticks(100);
        wr(2'd0, RESTART);
        ticks(64 * D - 1); check("R4 reload delays unf", 32'(fault_o), 0);
        ticks(1);          check("R4 unf after reload", 32'(fault_o), 1);
        rd(2'd2, d); check("R4 status", d, 1);

        // R8 lockout, R7 single write
        wr(2'd0, RESTART);
        ticks(2);
        wr(2'd1, cfg(5, 2, 1, 1, 0, 0, 0));
        rd(2'd1, d); check("R8 write in lockout ignored", d, 32'h003F_103F);
        ticks(1);
        wr(2'd1, cfg(5, 2, 1, 1, 0, 0, 0));
        rd(2'd1, d); check("R8 write after lockout", d, cfg(5, 2, 1, 1, 0, 0, 0));
        wr(2'd1, cfg(9, 9, 0, 0, 0, 0, 0));
        rd(2'd1, d); check("R7 second write ignored", d, cfg(5, 2, 1, 1, 0, 0, 0));

        // R7 config write reloaded counter to 5 (lockout write above did not)
        ticks(6 * D - 1); check("R7 reload on cfg", 32'(fault_o), 0);
        ticks(1); check("R10 irq", 32'(irq_o), 1);
        rd(2'd2, d); check("R2 unf", d, 1);
        check("R11 irq cleared", 32'(irq_o), 0);

        // R5 window sweep: wdv 5, wdd 2
        cur = 5;
        for (int c = 5; c >= 0; c--) begin
            ticks((cur - c) * D);
            cur = c;
            wr(2'd0, RESTART);
            if (c > 2) begin
                check("R5 early fault", 32'(fault_o), 1);
                rd(2'd2, d); check("R5 early err", d, 2);
            end else begin
                rd(2'd2, d); check("R5 in-window ok", d, 0);
                cur = 5;
            end
        end
        ticks(6 * D - 1); check("R5 in-window reload", 32'(fault_o), 0);
        ticks(1); check("R5 unf after reload", 32'(fault_o), 1);

        // R13 disabled, R5 error while disabled
        do_reset();
        wr(2'd1, cfg(5, 2, 1, 1, 1, 0, 0));
        ticks(100);
        rd(2'd2, d); check("R13 no unf when disabled", d, 0);
        wr(2'd0, RESTART);
        check("R5 irq on err while disabled", 32'(irq_o), 1);
        rd(2'd2, d); check("R5 err while disabled", d, 2);

        // R12 halts, R6 open window
        do_reset();
        wr(2'd1, cfg(3, 3, 0, 0, 0, 1, 1));
        idle_i = 1'b1; ticks(40);
        dbg_i = 1'b1;  ticks(40);
        idle_i = 1'b0; ticks(40);
        dbg_i = 1'b0;
        rd(2'd2, d); check("R12 frozen", d, 0);
        ticks(4 * D - 1);
        rd(2'd2, d); check("R12 resumes exact", d, 0);
        ticks(1);
        check("R2 no fault without rst_en", 32'(fault_o), 0);
        rd(2'd2, d); check("R2 unf flag", d, 1);
        cur = 3;
        for (int c = 3; c >= 0; c--) begin
            ticks((cur - c) * D);
            wr(2'd0, RESTART);
            rd(2'd2, d); check("R6 open window accept", d, 0);
            cur = 3;
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule